// File: doc/BRIEF.md
# Multi-View Integer Register File

This block holds sixteen 64-bit integer registers. Each register can be read or written at its full width, or through a narrower window: the low 32 bits, the low 16 bits or the low byte. Registers 0 to 3 also expose bits 15:8 as a byte of their own, called the high-byte view here. The block has two combinational read ports and one write port that commits on the clock edge. Each port carries a register index, a two-bit width code and a high-byte select.

A read returns the selected window placed at bit 0, with every bit above it cleared. A write does not simply replace the register. A 32-bit write clears the upper half of the register. A 16-bit or byte write changes only its own bits and keeps all other bits. A read that targets the register being written in the same cycle sees the merged value that is about to be stored.

A request for the high-byte view is illegal when the index is 4 or above, or when the width code is not the byte code. Such a request raises that port's illegal flag. An illegal write is dropped and an illegal read returns zero.

Top module: `alias_regfile`

## Requirements
- R1: When `rst` is high at a rising clock edge, every register becomes zero.
- R2: A 64-bit write (width code 2'b11) stores all of `wr_data`. A 64-bit read returns the whole register.
- R3: A 32-bit write (width code 2'b10) stores `wr_data[31:0]` in bits 31:0 and clears bits 63:32. A 32-bit read returns bits 31:0 with bits 63:32 of the result at zero.
- R4: A 16-bit write (width code 2'b01) stores `wr_data[15:0]` in bits 15:0 and leaves bits 63:16 unchanged. A 16-bit read returns bits 15:0 with the rest of the result at zero.
- R5: A low-byte access (width code 2'b00, high select 0) works on bits 7:0 of any register, including registers 4 to 7. A write leaves bits 63:8 unchanged. A read returns the byte in result bits 7:0 with the rest of the result at zero.
- R6: A high-byte access (width code 2'b00, high select 1, index 0 to 3) works on bits 15:8. A write stores `wr_data[7:0]` there and leaves all other bits unchanged. A read returns bits 15:8 in result bits 7:0 with the rest of the result at zero.
- R7: A read with high select 1 and either an index of 4 or more or a width code other than 2'b00 raises that port's illegal flag and returns zero.
- R8: A write with high select 1 under the same illegal conditions raises `wr_illegal` when `wr_en` is high, and leaves every register unchanged.
- R9: When a legal write and a read port address the same register in one cycle, that read port returns the merged value that the register will hold after the edge.
- R10: With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write width code: 00 byte, 01 16-bit, 10 32-bit, 11 64-bit |
| wr_hi | input | 1 | Write high-byte select |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Write request has an illegal view |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 has an illegal view |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 has an illegal view |

## Verification
The bench builds the block with its default parameters: sixteen registers, of which the first four have a high-byte view. These values bring the legality edge within reach from both sides, since index 3 is legal and indices 4 and 5 are not. They also cover the top index, 15. A single register is written through a chain of shrinking widths so that each merge rule acts on a value left by the one before. The same-cycle bypass is exercised with a partial-width write, so the forwarded word has to be the merged value and not the raw write data.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  localparam int XLEN = 64;
  typedef logic [XLEN-1:0] word_t;

  // width code of an access window
  typedef enum logic [1:0] {
    VW_B8  = 2'b00,
    VW_B16 = 2'b01,
    VW_B32 = 2'b10,
    VW_B64 = 2'b11
  } view_e;

  // true when the request names an existing window
  function automatic logic view_ok(input int idx, input view_e sz, input logic hi,
                                   input int hi_regs);
    return !hi || ((idx < hi_regs) && (sz == VW_B8));
  endfunction

  // selected window of a stored word, right-aligned and zero-extended
  function automatic word_t view_extract(input word_t w, input view_e sz, input logic hi);
    word_t r;
    r = '0;
    unique case (sz)
      VW_B64: r = w;
      VW_B32: r[31:0] = w[31:0];
      VW_B16: r[15:0] = w[15:0];
      VW_B8:  r[7:0]  = hi ? w[15:8] : w[7:0];
    endcase
    return r;
  endfunction

  // new stored word after a write through a window
  function automatic word_t view_merge(input word_t old, input word_t din,
                                       input view_e sz, input logic hi);
    word_t r;
    r = old;
    unique case (sz)
      VW_B64: r = din;
      VW_B32: r = {32'd0, din[31:0]};
      VW_B16: r[15:0] = din[15:0];
      VW_B8: begin
        if (hi) r[15:8] = din[7:0];
        else    r[7:0]  = din[7:0];
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gprf_view_decode.sv
module gprf_view_decode
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int HI_REGS  = 4,
  localparam int IDXW    = $clog2(NUM_REGS)
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      size_i,
  input  logic            hi_i,
  output view_e           size_o,
  output logic            illegal_o
);
  assign size_o    = view_e'(size_i);
  assign illegal_o = !view_ok(int'(idx_i), view_e'(size_i), hi_i, HI_REGS);
endmodule

// File: rtl/gprf_write_path.sv
module gprf_write_path
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int HI_REGS  = 4,
  localparam int IDXW    = $clog2(NUM_REGS)
) (
  input  logic                          en_i,
  input  logic [IDXW-1:0]               idx_i,
  input  logic [1:0]                    size_i,
  input  logic                          hi_i,
  input  word_t                         data_i,
  input  logic [NUM_REGS-1:0][XLEN-1:0] reg_q_i,
  output logic                          illegal_o,
  output logic [NUM_REGS-1:0]           commit_o,
  output word_t                         merged_o
);
  view_e sz;
  logic  bad;

  gprf_view_decode #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS)) u_dec (
    .idx_i    (idx_i),
    .size_i   (size_i),
    .hi_i     (hi_i),
    .size_o   (sz),
    .illegal_o(bad)
  );

  assign illegal_o = en_i && bad;
  assign merged_o  = view_merge(reg_q_i[idx_i], data_i, sz, hi_i);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_commit
    assign commit_o[g] = en_i && !bad && (idx_i == IDXW'(g));
  end
endmodule

// File: rtl/gprf_regstore.sv
module gprf_regstore
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_REGS-1:0]           commit_i,
  input  word_t                         merged_i,
  output logic [NUM_REGS-1:0][XLEN-1:0] reg_q_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)              reg_q_o[g] <= '0;
      else if (commit_i[g]) reg_q_o[g] <= merged_i;
    end
  end
endmodule

// File: rtl/gprf_read_port.sv
module gprf_read_port
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int HI_REGS  = 4,
  localparam int IDXW    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][XLEN-1:0] reg_q_i,
  input  logic [NUM_REGS-1:0]           byp_commit_i,
  input  word_t                         byp_word_i,
  input  logic [IDXW-1:0]               idx_i,
  input  logic [1:0]                    size_i,
  input  logic                          hi_i,
  output word_t                         data_o,
  output logic                          illegal_o
);
  view_e sz;
  logic  bad;
  word_t src;

  gprf_view_decode #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS)) u_dec (
    .idx_i    (idx_i),
    .size_i   (size_i),
    .hi_i     (hi_i),
    .size_o   (sz),
    .illegal_o(bad)
  );

  // write-first: a same-cycle commit to this index wins over the stored word
  assign src       = byp_commit_i[idx_i] ? byp_word_i : reg_q_i[idx_i];
  assign data_o    = bad ? '0 : view_extract(src, sz, hi_i);
  assign illegal_o = bad;
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int HI_REGS  = 4,
  localparam int IDXW    = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic [63:0]     wr_data,
  output logic            wr_illegal,
  input  logic [IDXW-1:0] rd0_idx,
  input  logic [1:0]      rd0_size,
  input  logic            rd0_hi,
  output logic [63:0]     rd0_data,
  output logic            rd0_illegal,
  input  logic [IDXW-1:0] rd1_idx,
  input  logic [1:0]      rd1_size,
  input  logic            rd1_hi,
  output logic [63:0]     rd1_data,
  output logic            rd1_illegal
);
  localparam int NUM_RD = 2;

  // internal events, named for the checker
  logic [NUM_REGS-1:0]           wr_commit;
  logic [NUM_REGS-1:0][XLEN-1:0] reg_q;
  word_t                         wr_merged;

  logic [IDXW-1:0] rp_idx [NUM_RD];
  logic [1:0]      rp_size[NUM_RD];
  logic            rp_hi  [NUM_RD];
  word_t           rp_data[NUM_RD];
  logic            rp_bad [NUM_RD];

  gprf_write_path #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS)) u_wr (
    .en_i     (wr_en),
    .idx_i    (wr_idx),
    .size_i   (wr_size),
    .hi_i     (wr_hi),
    .data_i   (wr_data),
    .reg_q_i  (reg_q),
    .illegal_o(wr_illegal),
    .commit_o (wr_commit),
    .merged_o (wr_merged)
  );

  gprf_regstore #(.NUM_REGS(NUM_REGS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .commit_i(wr_commit),
    .merged_i(wr_merged),
    .reg_q_o (reg_q)
  );

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_hi[0]   = rd0_hi;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;
  assign rp_hi[1]   = rd1_hi;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gprf_read_port #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS)) u_rd (
      .reg_q_i     (reg_q),
      .byp_commit_i(wr_commit),
      .byp_word_i  (wr_merged),
      .idx_i       (rp_idx[p]),
      .size_i      (rp_size[p]),
      .hi_i        (rp_hi[p]),
      .data_o      (rp_data[p]),
      .illegal_o   (rp_bad[p])
    );
  end

  assign rd0_data    = rp_data[0];
  assign rd0_illegal = rp_bad[0];
  assign rd1_data    = rp_data[1];
  assign rd1_illegal = rp_bad[1];
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
  import gprf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDXW    = $clog2(NUM_REGS)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [IDXW-1:0]               wr_idx,
  input logic [1:0]                    wr_size,
  input logic                          wr_illegal,
  input logic [NUM_REGS-1:0]           wr_commit,
  input logic [NUM_REGS-1:0][XLEN-1:0] reg_q,
  input logic [IDXW-1:0]               rd0_idx,
  input logic [1:0]                    rd0_size,
  input logic                          rd0_hi,
  input logic [63:0]                   rd0_data,
  input logic                          rd0_illegal,
  input logic [63:0]                   rd1_data,
  input logic                          rd1_illegal
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (reg_q == '0)); // R1

  AST_RD0_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> (rd0_data == '0)); // R7

  AST_RD1_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd1_illegal |-> (rd1_data == '0)); // R7

  AST_RD0_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (rd0_size == 2'b00) |-> (rd0_data[63:8] == '0)); // R5

  AST_ILLEGAL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |-> (wr_commit == '0)); // R8

  AST_COMMIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_commit)); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_commit == '0) |=> $stable(reg_q)); // R10

  AST_W32_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    ((|wr_commit) && (wr_size == 2'b10)) |=> (reg_q[$past(wr_idx)][63:32] == '0)); // R3

  AST_BYPASS_MATCH: assert property (@(posedge clk) disable iff (rst)
    ((|wr_commit) && (rd0_idx == wr_idx) && (rd0_size == 2'b11) && !rd0_hi)
      |=> (reg_q[$past(wr_idx)] == $past(rd0_data))); // R9
endmodule

bind alias_regfile alias_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_idx     (wr_idx),
  .wr_size    (wr_size),
  .wr_illegal (wr_illegal),
  .wr_commit  (wr_commit),
  .reg_q      (reg_q),
  .rd0_idx    (rd0_idx),
  .rd0_size   (rd0_size),
  .rd0_hi     (rd0_hi),
  .rd0_data   (rd0_data),
  .rd0_illegal(rd0_illegal),
  .rd1_data   (rd1_data),
  .rd1_illegal(rd1_illegal)
);

// File: tb/alias_regfile_test.sv
module alias_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] B8 = 2'b00, B16 = 2'b01, B32 = 2'b10, B64 = 2'b11;

  typedef struct packed {
    logic [3:0]  req;
    logic        wen;
    logic [3:0]  widx;
    logic [1:0]  wsz;
    logic        whi;
    logic [63:0] wdat;
    logic [3:0]  ridx;
    logic [1:0]  rsz;
    logic        rhi;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS[NV] = '{
    '{4'd2,  1'b1, 4'd2,  B64, 1'b0, 64'h1122334455667788, 4'd2,  B64, 1'b0, 64'h1122334455667788, 1'b0}, // R2
    '{4'd3,  1'b1, 4'd2,  B32, 1'b0, 64'hFFFFFFFF_AABBCCDD, 4'd2, B64, 1'b0, 64'h00000000_AABBCCDD, 1'b0}, // R3
    '{4'd4,  1'b1, 4'd2,  B16, 1'b0, 64'hDEADBEEF_00001234, 4'd2, B64, 1'b0, 64'h00000000_AABB1234, 1'b0}, // R4
    '{4'd5,  1'b1, 4'd2,  B8,  1'b0, 64'hFFFFFFFF_FFFFFF56, 4'd2, B64, 1'b0, 64'h00000000_AABB1256, 1'b0}, // R5
    '{4'd6,  1'b1, 4'd2,  B8,  1'b1, 64'h779A,             4'd2,  B64, 1'b0, 64'h00000000_AABB9A56, 1'b0}, // R6
    '{4'd6,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd2,  B8,  1'b1, 64'h9A,                1'b0}, // R6
    '{4'd4,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd2,  B16, 1'b0, 64'h9A56,              1'b0}, // R4
    '{4'd3,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd2,  B32, 1'b0, 64'hAABB9A56,          1'b0}, // R3
    '{4'd2,  1'b1, 4'd5,  B64, 1'b0, 64'h8877665544332211, 4'd5,  B64, 1'b0, 64'h8877665544332211, 1'b0}, // R2
    '{4'd5,  1'b1, 4'd5,  B8,  1'b0, 64'hEE,               4'd5,  B64, 1'b0, 64'h88776655443322EE, 1'b0}, // R5
    '{4'd5,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd5,  B8,  1'b0, 64'hEE,                1'b0}, // R5
    '{4'd8,  1'b1, 4'd5,  B8,  1'b1, 64'h77,               4'd5,  B64, 1'b0, 64'h88776655443322EE, 1'b0}, // R8
    '{4'd7,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd5,  B8,  1'b1, 64'h0,                 1'b1}, // R7
    '{4'd7,  1'b0, 4'd0,  B8,  1'b0, 64'h0,                4'd1,  B16, 1'b1, 64'h0,                 1'b1}, // R7
    '{4'd10, 1'b0, 4'd15, B64, 1'b0, 64'hFFFFFFFFFFFFFFFF, 4'd15, B64, 1'b0, 64'h0,                 1'b0}, // R10
    '{4'd6,  1'b1, 4'd3,  B8,  1'b1, 64'hC3,               4'd3,  B64, 1'b0, 64'h000000000000C300, 1'b0}, // R6
    '{4'd8,  1'b1, 4'd1,  B32, 1'b1, 64'h5555,             4'd1,  B64, 1'b0, 64'h0,                 1'b0}, // R8
    '{4'd2,  1'b1, 4'd15, B64, 1'b0, 64'hFEDCBA9876543210, 4'd15, B8,  1'b0, 64'h10,                1'b0}  // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_hi = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_illegal;
  logic [3:0]  rd0_idx = '0;
  logic [1:0]  rd0_size = '0;
  logic        rd0_hi = 1'b0;
  logic [63:0] rd0_data;
  logic        rd0_illegal;
  logic [3:0]  rd1_idx = '0;
  logic [1:0]  rd1_size = '0;
  logic        rd1_hi = 1'b0;
  logic [63:0] rd1_data;
  logic        rd1_illegal;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_regfile uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
    .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
    .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    rd0_idx = 4'd2; rd0_size = B64;
    rd1_idx = 4'd15; rd1_size = B64;
    #1;
    check("R1 reset r2", rd0_data, 64'h0);
    check("R1 reset r15", rd1_data, 64'h0);

    // table walk: write, then read the stored value with the write released
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VECS[i].wen; wr_idx = VECS[i].widx; wr_size = VECS[i].wsz;
      wr_hi = VECS[i].whi; wr_data = VECS[i].wdat;
      rd0_idx = VECS[i].ridx; rd0_size = VECS[i].rsz; rd0_hi = VECS[i].rhi;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), rd0_data, VECS[i].exp);
      check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), 64'(rd0_illegal), 64'(VECS[i].ill));
    end

    // R8: write flag for a high-byte request on register 9
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_size = B8; wr_hi = 1'b1; wr_data = 64'hAB;
    #1;
    check("R8 wr_illegal raised", 64'(wr_illegal), 64'h1);
    wr_en = 1'b0;
    #1;
    check("R8 wr_illegal needs wr_en", 64'(wr_illegal), 64'h0);

    // R9: full-width same-cycle bypass on port 1
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_size = B64; wr_hi = 1'b0; wr_data = 64'hA5A5_5A5A_0F0F_F0F0;
    rd1_idx = 4'd7; rd1_size = B64; rd1_hi = 1'b0;
    #1;
    check("R9 bypass full", rd1_data, 64'hA5A5_5A5A_0F0F_F0F0);

    // R9: merged bypass, register 2 holds 00000000_AABB9A56
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd2; wr_size = B16; wr_hi = 1'b0; wr_data = 64'hFFFF_4321;
    rd0_idx = 4'd2; rd0_size = B64; rd0_hi = 1'b0;
    rd1_idx = 4'd2; rd1_size = B8;  rd1_hi = 1'b1;
    #1;
    check("R9 bypass merged", rd0_data, 64'h00000000_AABB4321);
    check("R9 bypass high byte", rd1_data, 64'h43);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R4 stored after bypass", rd0_data, 64'h00000000_AABB4321);

    // R1: reset clears everything written above
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd0_size = B64; rd0_hi = 1'b0;
    for (int r = 0; r < 16; r++) begin
      rd0_idx = 4'(r);
      #1;
      check($sformatf("R1 cleared r%0d", r), rd0_data, 64'h0);
    end

    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule